// File: doc/BRIEF.md
# Superslice dispatch slot allocator

This block sits after decode. Each cycle it receives a group of up to eight decoded operations, given in program order, and assigns each one a dispatch port and a target slice. At most six of them are accepted. The execution side has four slices arranged as two superslices. Superslice 0 holds slices 0 (even) and 1 (odd). Superslice 1 holds slices 2 (even) and 3 (odd). Every slice has its own dedicated port. Each superslice also has one flexible port that can reach either of its slices. A separate branch slice is fed by two branch-only ports.

Every operation carries a valid bit, a branch flag, a rule class and a primary source count. The rule class constrains placement:
- A vector operation is delivered to both slices of a superslice.
- An even-only operation also uses up its odd neighbour's port.
- Two paired operations must land together on one superslice.
- A restricted operation takes a superslice for itself alone.

Acceptance is strictly in order. The first operation that cannot be placed stalls, and so does every operation after it. Results are registered and appear one clock after the group is presented.

Top module: `dispatch_slot_alloc`

## Requirements
- R1: An active-low asynchronous reset clears every output to zero at once. Otherwise the outputs show, one clock edge later, the allocation of the group present before that edge.
- R2: Placed lanes always form a prefix starting at lane 0. An invalid lane, and every lane after it, is not placed. Unplaced lanes report port 0, slice 0 and dual 0. acceptCount equals the number of placed lanes.
- R3: No more than MAX_ACCEPT (6) operations are placed per cycle. An operation that would exceed this limit stalls even when a port is free.
- R4: Class 0 is normal; codes 5 to 7 behave the same way. A normal operation first takes the lowest free dedicated port 0 to 3, whose port code equals its slice number. Otherwise it takes flexible port 4 (superslice 0), then flexible port 5 (superslice 1), provided its source count is at most 2. On a flexible port the even slice is preferred when it has room, otherwise the odd slice. An operation with no usable port stalls.
- R5: No execution slice receives more than two operations in one cycle. A vector counts once on each of its two slices.
- R6: An operation with the branch flag ignores its class and uses only branch ports 6, then 7, with slice code 4. A third branch in a cycle stalls.
- R7: A vector (class 1) uses one port of a superslice whose two slices both have room. The ports are tried in the order even dedicated, odd dedicated, flexible. It reports the even slice with dual = 1.
- R8: An even-only operation (class 2) needs both dedicated ports of a superslice to be free and room on the even slice. It reports the even dedicated port and the even slice, and the odd dedicated port becomes unavailable.
- R9: A paired operation (class 3) must be immediately followed by another class-3, non-branch, valid operation. Together they take the even and odd dedicated ports of one superslice: the first gets the even port and slice, the second the odd. Otherwise neither is placed. A paired operation without such a partner stalls.
- R10: A restricted operation (class 4) needs a superslice on which nothing has been placed. It reports that superslice's even dedicated port and even slice, and no later operation in the cycle may use either of its slices or its flexible port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | LANES | Lane holds an operation |
| opBranch | input | LANES | Lane is a branch operation |
| opClass | input | 3*LANES | Rule class per lane |
| opSrcCnt | input | 2*LANES | Primary source count per lane |
| opPlaced | output | LANES | Lane was accepted |
| opPort | output | 3*LANES | Assigned port code per lane |
| opSlice | output | 3*LANES | Assigned slice code per lane (4 = branch slice) |
| opDual | output | LANES | Lane delivered to both slices of a superslice |
| acceptCount | output | 4 | Number of accepted lanes |

## Verification
The checks on branch routing, flexible-port source limits, even-only and restricted placement compare each registered result with the inputs one cycle earlier. They therefore assume the group inputs are held steady across the capturing edge. The bench guarantees this by changing inputs only on the falling edge. Port-uniqueness and slice-load checks read the slice codes directly. This holds because a correct design reports every placed non-branch lane with a code below 4, and stalled lanes are cleared to zero. The stimulus keeps source counts at 1 to 3 and uses only the defined class codes, so every placement follows from R4 to R10.

// File: rtl/dispatch_slot_pkg.sv
package dispatch_slot_pkg;

  localparam int NUM_SS      = 2;
  localparam int NUM_SLICES  = 2 * NUM_SS;
  localparam int FLEX_BASE   = NUM_SLICES;
  localparam int NUM_BR      = 2;
  localparam int BR_BASE     = FLEX_BASE + NUM_SS;
  localparam int NUM_PORTS   = BR_BASE + NUM_BR;
  localparam int SLICE_BR    = NUM_SLICES;

  localparam int CLS_W   = 3;
  localparam int SRC_W   = 2;
  localparam int PORT_W  = $clog2(NUM_PORTS);
  localparam int SLICE_W = $clog2(NUM_SLICES + 1);
  localparam int LOAD_W  = 2;

  localparam logic [LOAD_W-1:0] SLICE_CAP    = 2'd2;
  localparam logic [SRC_W-1:0]  FLEX_MAX_SRC = 2'd2;

  typedef enum logic [CLS_W-1:0] {
    RC_NORMAL   = 3'd0,
    RC_VECTOR   = 3'd1,
    RC_EVEN     = 3'd2,
    RC_PAIRED   = 3'd3,
    RC_RESTRICT = 3'd4
  } ruleClassE;

  // Per-lane strobe bundle passed from control to datapath
  typedef struct packed {
    logic               placed;
    logic [PORT_W-1:0]  port;
    logic [SLICE_W-1:0] slice;
    logic               dual;
  } laneGrantT;

  function automatic laneGrantT mkGrant(int port, int slice, logic dual);
    laneGrantT g;
    g.placed = 1'b1;
    g.port   = PORT_W'(port);
    g.slice  = SLICE_W'(slice);
    g.dual   = dual;
    return g;
  endfunction

endpackage

// File: rtl/dispatch_slot_ctrl.sv
module dispatch_slot_ctrl
  import dispatch_slot_pkg::*;
#(
  parameter int LANES      = 8,
  parameter int MAX_ACCEPT = 6,
  localparam int CNT_W     = $clog2(LANES + 3)
) (
  input  logic [LANES-1:0]       opValid,
  input  logic [LANES-1:0]       opBranch,
  input  logic [LANES*CLS_W-1:0] opClass,
  input  logic [LANES*SRC_W-1:0] opSrcCnt,
  output laneGrantT [LANES-1:0]  grant,
  output logic [CNT_W-1:0]       acceptCnt
);

  logic [LANES-1:0] pairReq;
  logic [LANES-1:0] partnerOk;

  for (genvar g = 0; g < LANES; g++) begin : g_pair
    assign pairReq[g] = opValid[g] && !opBranch[g] &&
                        (opClass[g*CLS_W +: CLS_W] == RC_PAIRED);
  end
  // bit i set when lane i+1 can complete a pair
  assign partnerOk = pairReq >> 1;

  logic [NUM_PORTS-1:0] portBusy;
  logic [LOAD_W-1:0]    sliceLoad [NUM_SLICES];
  logic [NUM_SS-1:0]    ssLock;
  logic                 halted, skipNext, done;
  logic [CNT_W-1:0]     taken, cost;
  logic [SRC_W-1:0]     src;
  logic [CLS_W-1:0]     cls;
  int                   pairSs;

  always_comb begin
    portBusy = '0;
    for (int s = 0; s < NUM_SLICES; s++) sliceLoad[s] = '0;
    ssLock   = '0;
    halted   = 1'b0;
    skipNext = 1'b0;
    done     = 1'b0;
    taken    = '0;
    cost     = '0;
    src      = '0;
    cls      = '0;
    pairSs   = 0;
    for (int i = 0; i < LANES; i++) grant[i] = '0;

    for (int i = 0; i < LANES; i++) begin
      src  = opSrcCnt[i*SRC_W +: SRC_W];
      cls  = opClass[i*CLS_W +: CLS_W];
      done = 1'b0;
      cost = CNT_W'(1);
      if (skipNext) begin
        // second half of a pair already reserved on the odd side
        grant[i] = mkGrant(2*pairSs + 1, 2*pairSs + 1, 1'b0);
        skipNext = 1'b0;
      end else if (!halted) begin
        if (!opValid[i] || taken >= CNT_W'(MAX_ACCEPT)) begin
          halted = 1'b1;
        end else if (opBranch[i]) begin
          for (int b = 0; b < NUM_BR; b++) begin
            if (!done && !portBusy[BR_BASE+b]) begin
              grant[i] = mkGrant(BR_BASE + b, SLICE_BR, 1'b0);
              portBusy[BR_BASE+b] = 1'b1;
              done = 1'b1;
            end
          end
        end else begin
          case (cls)
            RC_VECTOR: begin
              for (int ss = 0; ss < NUM_SS; ss++) begin
                if (!done && !ssLock[ss] && sliceLoad[2*ss] < SLICE_CAP &&
                    sliceLoad[2*ss+1] < SLICE_CAP) begin
                  if (!portBusy[2*ss]) begin
                    grant[i] = mkGrant(2*ss, 2*ss, 1'b1);
                    portBusy[2*ss] = 1'b1;
                    done = 1'b1;
                  end else if (!portBusy[2*ss+1]) begin
                    grant[i] = mkGrant(2*ss + 1, 2*ss, 1'b1);
                    portBusy[2*ss+1] = 1'b1;
                    done = 1'b1;
                  end else if (src <= FLEX_MAX_SRC && !portBusy[FLEX_BASE+ss]) begin
                    grant[i] = mkGrant(FLEX_BASE + ss, 2*ss, 1'b1);
                    portBusy[FLEX_BASE+ss] = 1'b1;
                    done = 1'b1;
                  end
                  if (done) begin
                    sliceLoad[2*ss]   = sliceLoad[2*ss] + 1'b1;
                    sliceLoad[2*ss+1] = sliceLoad[2*ss+1] + 1'b1;
                  end
                end
              end
            end
            RC_EVEN: begin
              for (int ss = 0; ss < NUM_SS; ss++) begin
                if (!done && !ssLock[ss] && !portBusy[2*ss] && !portBusy[2*ss+1] &&
                    sliceLoad[2*ss] < SLICE_CAP) begin
                  grant[i] = mkGrant(2*ss, 2*ss, 1'b0);
                  portBusy[2*ss]   = 1'b1;
                  portBusy[2*ss+1] = 1'b1;
                  sliceLoad[2*ss]  = sliceLoad[2*ss] + 1'b1;
                  done = 1'b1;
                end
              end
            end
            RC_PAIRED: begin
              if (partnerOk[i] && (taken + CNT_W'(2) <= CNT_W'(MAX_ACCEPT))) begin
                for (int ss = 0; ss < NUM_SS; ss++) begin
                  if (!done && !ssLock[ss] && !portBusy[2*ss] && !portBusy[2*ss+1] &&
                      sliceLoad[2*ss] < SLICE_CAP && sliceLoad[2*ss+1] < SLICE_CAP) begin
                    grant[i] = mkGrant(2*ss, 2*ss, 1'b0);
                    portBusy[2*ss]    = 1'b1;
                    portBusy[2*ss+1]  = 1'b1;
                    sliceLoad[2*ss]   = sliceLoad[2*ss] + 1'b1;
                    sliceLoad[2*ss+1] = sliceLoad[2*ss+1] + 1'b1;
                    pairSs   = ss;
                    skipNext = 1'b1;
                    cost     = CNT_W'(2);
                    done     = 1'b1;
                  end
                end
              end
            end
            RC_RESTRICT: begin
              for (int ss = 0; ss < NUM_SS; ss++) begin
                if (!done && !ssLock[ss] && sliceLoad[2*ss] == '0 &&
                    sliceLoad[2*ss+1] == '0 && !portBusy[FLEX_BASE+ss]) begin
                  grant[i] = mkGrant(2*ss, 2*ss, 1'b0);
                  portBusy[2*ss]         = 1'b1;
                  portBusy[2*ss+1]       = 1'b1;
                  portBusy[FLEX_BASE+ss] = 1'b1;
                  sliceLoad[2*ss]        = sliceLoad[2*ss] + 1'b1;
                  ssLock[ss]             = 1'b1;
                  done = 1'b1;
                end
              end
            end
            default: begin
              for (int s = 0; s < NUM_SLICES; s++) begin
                if (!done && !portBusy[s] && !ssLock[s/2] && sliceLoad[s] < SLICE_CAP) begin
                  grant[i] = mkGrant(s, s, 1'b0);
                  portBusy[s]  = 1'b1;
                  sliceLoad[s] = sliceLoad[s] + 1'b1;
                  done = 1'b1;
                end
              end
              if (src <= FLEX_MAX_SRC) begin
                for (int ss = 0; ss < NUM_SS; ss++) begin
                  if (!done && !ssLock[ss] && !portBusy[FLEX_BASE+ss]) begin
                    if (sliceLoad[2*ss] < SLICE_CAP) begin
                      grant[i] = mkGrant(FLEX_BASE + ss, 2*ss, 1'b0);
                      sliceLoad[2*ss] = sliceLoad[2*ss] + 1'b1;
                      portBusy[FLEX_BASE+ss] = 1'b1;
                      done = 1'b1;
                    end else if (sliceLoad[2*ss+1] < SLICE_CAP) begin
                      grant[i] = mkGrant(FLEX_BASE + ss, 2*ss + 1, 1'b0);
                      sliceLoad[2*ss+1] = sliceLoad[2*ss+1] + 1'b1;
                      portBusy[FLEX_BASE+ss] = 1'b1;
                      done = 1'b1;
                    end
                  end
                end
              end
            end
          endcase
        end
        if (!halted) begin
          if (done) taken = taken + cost;
          else      halted = 1'b1;
        end
      end
    end
  end

  assign acceptCnt = taken;

endmodule

// File: rtl/dispatch_slot_dp.sv
module dispatch_slot_dp
  import dispatch_slot_pkg::*;
#(
  parameter int LANES = 8,
  parameter int CNT_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  laneGrantT [LANES-1:0] grant,
  input  logic [CNT_W-1:0]      acceptCnt,
  output laneGrantT [LANES-1:0] grantQ,
  output logic [CNT_W-1:0]      acceptQ
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) grantQ[g] <= '0;
      else       grantQ[g] <= grant[g];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) acceptQ <= '0;
    else       acceptQ <= acceptCnt;
  end

endmodule

// File: rtl/dispatch_slot_alloc.sv
module dispatch_slot_alloc
  import dispatch_slot_pkg::*;
#(
  parameter int LANES      = 8,
  parameter int MAX_ACCEPT = 6,
  localparam int CNT_W     = $clog2(LANES + 3)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [LANES-1:0]         opValid,
  input  logic [LANES-1:0]         opBranch,
  input  logic [LANES*CLS_W-1:0]   opClass,
  input  logic [LANES*SRC_W-1:0]   opSrcCnt,
  output logic [LANES-1:0]         opPlaced,
  output logic [LANES*PORT_W-1:0]  opPort,
  output logic [LANES*SLICE_W-1:0] opSlice,
  output logic [LANES-1:0]         opDual,
  output logic [CNT_W-1:0]         acceptCount
);

  laneGrantT [LANES-1:0] grant;
  laneGrantT [LANES-1:0] grantQ;
  logic [CNT_W-1:0]      acceptCnt;

  dispatch_slot_ctrl #(.LANES(LANES), .MAX_ACCEPT(MAX_ACCEPT)) u_ctrl (
    .opValid   (opValid),
    .opBranch  (opBranch),
    .opClass   (opClass),
    .opSrcCnt  (opSrcCnt),
    .grant     (grant),
    .acceptCnt (acceptCnt)
  );

  dispatch_slot_dp #(.LANES(LANES), .CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .grant     (grant),
    .acceptCnt (acceptCnt),
    .grantQ    (grantQ),
    .acceptQ   (acceptCount)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_out
    assign opPlaced[g]                   = grantQ[g].placed;
    assign opPort[g*PORT_W +: PORT_W]    = grantQ[g].port;
    assign opSlice[g*SLICE_W +: SLICE_W] = grantQ[g].slice;
    assign opDual[g]                     = grantQ[g].dual;
  end

endmodule

// File: rtl/dispatch_slot_chk.sv
module dispatch_slot_chk
  import dispatch_slot_pkg::*;
#(
  parameter int LANES      = 8,
  parameter int MAX_ACCEPT = 6,
  localparam int CNT_W     = $clog2(LANES + 3)
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [LANES-1:0]         opValid,
  input logic [LANES-1:0]         opBranch,
  input logic [LANES*CLS_W-1:0]   opClass,
  input logic [LANES*SRC_W-1:0]   opSrcCnt,
  input logic [LANES-1:0]         opPlaced,
  input logic [LANES*PORT_W-1:0]  opPort,
  input logic [LANES*SLICE_W-1:0] opSlice,
  input logic [LANES-1:0]         opDual,
  input logic [CNT_W-1:0]         acceptCount
);

  logic [3:0] portHits  [NUM_PORTS];
  logic [3:0] sliceHits [NUM_SLICES];
  logic       portClash, sliceOver;

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) portHits[p] = '0;
    for (int s = 0; s < NUM_SLICES; s++) sliceHits[s] = '0;
    for (int i = 0; i < LANES; i++) begin
      if (opPlaced[i]) begin
        portHits[int'(opPort[i*PORT_W +: PORT_W])] =
          portHits[int'(opPort[i*PORT_W +: PORT_W])] + 4'd1;
        if (int'(opSlice[i*SLICE_W +: SLICE_W]) < NUM_SLICES) begin
          sliceHits[int'(opSlice[i*SLICE_W +: SLICE_W])] =
            sliceHits[int'(opSlice[i*SLICE_W +: SLICE_W])] + 4'd1;
          if (opDual[i] && int'(opSlice[i*SLICE_W +: SLICE_W]) + 1 < NUM_SLICES)
            sliceHits[int'(opSlice[i*SLICE_W +: SLICE_W]) + 1] =
              sliceHits[int'(opSlice[i*SLICE_W +: SLICE_W]) + 1] + 4'd1;
        end
      end
    end
    portClash = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) if (portHits[p] > 4'd1) portClash = 1'b1;
    sliceOver = 1'b0;
    for (int s = 0; s < NUM_SLICES; s++) if (sliceHits[s] > 4'd2) sliceOver = 1'b1;
  end

  // R2
  prefix_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((opPlaced + 1'b1) & opPlaced) == '0);

  // R2
  count_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    32'(acceptCount) == $countones(opPlaced));

  // R3
  accept_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    32'(acceptCount) <= MAX_ACCEPT);

  // R4
  port_unique_chk: assert property (@(posedge clk) disable iff (!rstN) !portClash);

  // R5
  slice_cap_chk: assert property (@(posedge clk) disable iff (!rstN) !sliceOver);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // R2
    placed_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
      opPlaced[g] |-> $past(opValid[g]));

    // R6
    branch_route_chk: assert property (@(posedge clk) disable iff (!rstN)
      opPlaced[g] |-> ($past(opBranch[g]) ==
                       (int'(opPort[g*PORT_W +: PORT_W]) >= BR_BASE &&
                        int'(opSlice[g*SLICE_W +: SLICE_W]) == SLICE_BR)));

    // R4
    flex_src_chk: assert property (@(posedge clk) disable iff (!rstN)
      (opPlaced[g] && int'(opPort[g*PORT_W +: PORT_W]) >= FLEX_BASE &&
       int'(opPort[g*PORT_W +: PORT_W]) < BR_BASE)
      |-> $past(opSrcCnt[g*SRC_W +: SRC_W]) <= FLEX_MAX_SRC);

    // R7
    dual_even_chk: assert property (@(posedge clk) disable iff (!rstN)
      opDual[g] |-> (opPlaced[g] && !opSlice[g*SLICE_W] &&
                     int'(opSlice[g*SLICE_W +: SLICE_W]) < NUM_SLICES));

    // R8
    even_only_chk: assert property (@(posedge clk) disable iff (!rstN)
      (opPlaced[g] && $past(!opBranch[g]) &&
       $past(opClass[g*CLS_W +: CLS_W]) == RC_EVEN)
      |-> (!opSlice[g*SLICE_W] && int'(opPort[g*PORT_W +: PORT_W]) < NUM_SLICES));

    // R10
    restrict_chk: assert property (@(posedge clk) disable iff (!rstN)
      (opPlaced[g] && $past(!opBranch[g]) &&
       $past(opClass[g*CLS_W +: CLS_W]) == RC_RESTRICT)
      |-> (!opSlice[g*SLICE_W] && int'(opPort[g*PORT_W +: PORT_W]) < NUM_SLICES));
  end

endmodule

bind dispatch_slot_alloc dispatch_slot_chk #(.LANES(LANES), .MAX_ACCEPT(MAX_ACCEPT)) u_chk (.*);

// File: tb/dispatch_slot_alloc_tb.sv
module dispatch_slot_alloc_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LANES      = 8;
  localparam int NVEC       = 12;

  typedef struct packed {
    logic       v;
    logic       br;
    logic [2:0] cls;
    logic [1:0] src;
  } opT;

  typedef struct packed {
    logic       pl;
    logic [2:0] port;
    logic [2:0] slc;
    logic       dual;
  } resT;

  typedef struct packed {
    opT  [LANES-1:0] ops;
    resT [LANES-1:0] res;
    logic [3:0]      cnt;
  } vecT;

  function automatic opT mkOp(int br, int cls, int src);
    opT o;
    o.v   = 1'b1;
    o.br  = 1'(br);
    o.cls = 3'(cls);
    o.src = 2'(src);
    return o;
  endfunction

  function automatic resT mkRes(int port, int slc, int dual);
    resT r;
    r.pl   = 1'b1;
    r.port = 3'(port);
    r.slc  = 3'(slc);
    r.dual = 1'(dual);
    return r;
  endfunction

  localparam opT  NOP = '0;
  localparam resT NR  = '0;

  // lanes listed 7 down to 0; class 0 normal, 1 vector, 2 even-only, 3 paired, 4 restricted
  localparam vecT VECS [NVEC] = '{
    // 0: eight normal, dedicated then flexible
    '{ops: {mkOp(0,0,2), mkOp(0,0,2), mkOp(0,0,2), mkOp(0,0,2),
            mkOp(0,0,2), mkOp(0,0,2), mkOp(0,0,2), mkOp(0,0,2)},
      res: {NR, NR, mkRes(5,2,0), mkRes(4,0,0), mkRes(3,3,0), mkRes(2,2,0),
            mkRes(1,1,0), mkRes(0,0,0)}, cnt: 4'd6},
    // 1: six-op cap with free flexible ports
    '{ops: {mkOp(0,0,2), mkOp(0,0,2), mkOp(1,0,2), mkOp(1,0,2),
            mkOp(0,0,2), mkOp(0,0,2), mkOp(0,0,2), mkOp(0,0,2)},
      res: {NR, NR, mkRes(7,4,0), mkRes(6,4,0), mkRes(3,3,0), mkRes(2,2,0),
            mkRes(1,1,0), mkRes(0,0,0)}, cnt: 4'd6},
    // 2: three sources blocks flexible port, in-order stall
    '{ops: {NOP, NOP, mkOp(0,0,1), mkOp(0,0,3),
            mkOp(0,0,2), mkOp(0,0,2), mkOp(0,0,2), mkOp(0,0,2)},
      res: {NR, NR, NR, NR, mkRes(3,3,0), mkRes(2,2,0),
            mkRes(1,1,0), mkRes(0,0,0)}, cnt: 4'd4},
    // 3: vectors fill superslice 0, slice cap blocks flexible 0
    '{ops: {NOP, NOP, mkOp(0,0,2), mkOp(0,0,2),
            mkOp(0,0,2), mkOp(0,1,2), mkOp(0,1,2), mkOp(0,1,2)},
      res: {NR, NR, NR, mkRes(5,2,0), mkRes(3,3,0), mkRes(2,2,1),
            mkRes(1,0,1), mkRes(0,0,1)}, cnt: 4'd5},
    // 4: even-only consumes odd dedicated port
    '{ops: {NOP, NOP, mkOp(0,0,2), mkOp(0,0,2),
            mkOp(0,0,2), mkOp(0,0,2), mkOp(0,2,2), mkOp(0,0,2)},
      res: {NR, NR, NR, mkRes(5,2,0), mkRes(4,0,0), mkRes(1,1,0),
            mkRes(2,2,0), mkRes(0,0,0)}, cnt: 4'd5},
    // 5: second pair has no superslice, both stall
    '{ops: {NOP, NOP, mkOp(0,0,2), mkOp(0,3,2),
            mkOp(0,3,2), mkOp(0,0,2), mkOp(0,3,2), mkOp(0,3,2)},
      res: {NR, NR, NR, NR, NR, mkRes(2,2,0),
            mkRes(1,1,0), mkRes(0,0,0)}, cnt: 4'd3},
    // 6: pair falls to superslice 1
    '{ops: {NOP, NOP, NOP, NOP,
            mkOp(0,0,2), mkOp(0,3,2), mkOp(0,3,2), mkOp(0,0,2)},
      res: {NR, NR, NR, NR, mkRes(1,1,0), mkRes(3,3,0),
            mkRes(2,2,0), mkRes(0,0,0)}, cnt: 4'd4},
    // 7: restricted locks superslice 0
    '{ops: {NOP, NOP, NOP, mkOp(0,4,2),
            mkOp(0,0,2), mkOp(0,0,2), mkOp(0,0,2), mkOp(0,4,2)},
      res: {NR, NR, NR, NR, mkRes(5,2,0), mkRes(3,3,0),
            mkRes(2,2,0), mkRes(0,0,0)}, cnt: 4'd4},
    // 8: restricted skips busy superslice 0, locks 1
    '{ops: {NOP, NOP, NOP, mkOp(0,0,2),
            mkOp(0,0,2), mkOp(0,0,2), mkOp(0,4,2), mkOp(0,0,2)},
      res: {NR, NR, NR, NR, mkRes(4,0,0), mkRes(1,1,0),
            mkRes(2,2,0), mkRes(0,0,0)}, cnt: 4'd4},
    // 9: branches ignore class, third branch stalls
    '{ops: {NOP, NOP, NOP, mkOp(0,0,2),
            mkOp(1,0,2), mkOp(1,0,2), mkOp(0,0,2), mkOp(1,4,2)},
      res: {NR, NR, NR, NR, NR, mkRes(7,4,0),
            mkRes(0,0,0), mkRes(6,4,0)}, cnt: 4'd3},
    // 10: invalid lane ends the group
    '{ops: {NOP, NOP, NOP, NOP, NOP, mkOp(0,0,2), NOP, mkOp(0,0,2)},
      res: {NR, NR, NR, NR, NR, NR, NR, mkRes(0,0,0)}, cnt: 4'd1},
    // 11: paired op without a paired successor
    '{ops: {NOP, NOP, NOP, NOP, NOP, mkOp(0,0,2), mkOp(0,3,2), mkOp(0,0,2)},
      res: {NR, NR, NR, NR, NR, NR, NR, mkRes(0,0,0)}, cnt: 4'd1}
  };

  function automatic string tagOf(int idx);
    case (idx)
      0, 2:     return "R4";
      1:        return "R3";
      3:        return "R7,R5";
      4:        return "R8";
      5, 6, 11: return "R9";
      7, 8:     return "R10";
      9:        return "R6";
      default:  return "R2";
    endcase
  endfunction

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [LANES-1:0] opValid = '0, opBranch = '0;
  logic [3*LANES-1:0] opClass = '0;
  logic [2*LANES-1:0] opSrcCnt = '0;
  logic [LANES-1:0] opPlaced, opDual;
  logic [3*LANES-1:0] opPort, opSlice;
  logic [3:0]       acceptCount;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  dispatch_slot_alloc u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opBranch(opBranch),
    .opClass(opClass), .opSrcCnt(opSrcCnt), .opPlaced(opPlaced),
    .opPort(opPort), .opSlice(opSlice), .opDual(opDual),
    .acceptCount(acceptCount)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic drive(input opT [LANES-1:0] ops);
    for (int i = 0; i < LANES; i++) begin
      opValid[i]          = ops[i].v;
      opBranch[i]         = ops[i].br;
      opClass[i*3 +: 3]   = ops[i].cls;
      opSrcCnt[i*2 +: 2]  = ops[i].src;
    end
  endtask

  function automatic resT laneOut(int i);
    resT r;
    r.pl   = opPlaced[i];
    r.port = opPort[i*3 +: 3];
    r.slc  = opSlice[i*3 +: 3];
    r.dual = opDual[i];
    return r;
  endfunction

  task automatic checkAll(input string tag, input int idx,
                          input resT [LANES-1:0] exp, input logic [3:0] expCnt);
    for (int i = 0; i < LANES; i++) begin
      checks++;
      if (laneOut(i) !== exp[i]) begin
        errors++;
        $display("FAIL %s case %0d lane %0d: got %h expected %h", tag, idx, i, laneOut(i), exp[i]);
      end
    end
    checks++;
    if (acceptCount !== expCnt) begin
      errors++;
      $display("FAIL %s case %0d count: got %0d expected %0d", tag, idx, acceptCount, expCnt);
    end
  endtask

  initial begin
    resT [LANES-1:0] zeroRes;
    opT  [LANES-1:0] idle;
    zeroRes = '0;
    idle    = '0;
    repeat (3) @(negedge clk);
    checkAll("R1", 100, zeroRes, 4'd0);   // reset state
    rstN = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      drive(VECS[v].ops);
      @(negedge clk);
      checkAll(tagOf(v), v, VECS[v].res, VECS[v].cnt);
    end

    // idle group clears results after one edge (R1, R2)
    drive(idle);
    @(negedge clk);
    checkAll("R1", 101, zeroRes, 4'd0);

    // results appear only after the capturing edge (R1)
    drive(VECS[0].ops);
    #1;
    checkAll("R1", 102, zeroRes, 4'd0);
    @(negedge clk);
    checkAll("R4", 103, VECS[0].res, VECS[0].cnt);

    // asynchronous reset clears outputs at once (R1)
    rstN = 1'b0;
    #1;
    checkAll("R1", 104, zeroRes, 4'd0);
    @(negedge clk);
    rstN = 1'b1;
    drive(idle);
    @(negedge clk);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule